// File: doc/BRIEF.md
# Instruction Fetch Trap-Opcode Patcher

This block sits in the instruction fetch path between the on-chip program ROM and the CPU. Software programs up to two 24-bit byte addresses into it and arms each one with its own enable bit. The block watches every fetch. When an armed address names one of the bytes being fetched, and that byte lies inside the on-chip ROM window, the block hands the CPU the one-byte software-interrupt opcode 01h in place of the ROM byte. The CPU then traps into a patch handler, which lets firmware bugs in mask ROM be worked around.

The fetch path is two byte lanes wide. Each lane is compared and substituted on its own, and the data path adds no register. The comparators read the live register contents. A write therefore takes effect on the next cycle, even while a channel is armed, so software should disarm a channel before it rewrites that channel's address. Each channel also keeps a sticky hit flag. The flag is set when a valid fetch is patched by that channel, and software clears it by writing a 1 to it.

Top module: `fetch_patch_unit`

## Requirements
- R1: After reset, all six address bytes, both enable bits and both hit flags read as 00h / 0.
- R2: Register offsets on `reg_addr`: channel 0 low/middle/bank bytes at 0/1/2; channel 1 low/middle/bank bytes at 4/5/6; enables at 8 (bit 0 = channel 0, bit 1 = channel 1, other bits read 0); hit flags at 9 (same bit order). Every other offset reads 00h, and writes to it have no effect. Written values read back on the next cycle.
- R3: A lane whose byte address equals the address of an enabled channel, and lies inside the ROM window, outputs 01h. Every other lane outputs its ROM byte unchanged.
- R4: A channel whose enable bit is 0 never causes a substitution.
- R5: The ROM window is ROM_LO..ROM_HI inclusive (default FF0000h..FFFFFFh). A lane address outside it is never substituted, even when a detect address equals it.
- R6: Lane 0 (`rom_data[7:0]`) carries the byte at `fetch_addr` with bit 0 cleared. Lane 1 (`rom_data[15:8]`) carries the byte at that address plus 1. An odd `fetch_addr` therefore behaves exactly like the even address below it.
- R7: Substitution is combinational. `fetch_data` reflects `fetch_addr` and `rom_data` within the same cycle, with no clock edge in between.
- R8: When both channels match the same byte, that byte is output as a single 01h.
- R9: The comparison uses the live register contents. An address byte written while the channel is enabled changes the matched address from the next cycle on.
- R10: A channel's hit flag becomes 1 on the clock edge at which `fetch_valid` is high and that channel substitutes a lane. The flag then stays 1 until it is cleared.
- R11: Writing offset 9 clears each hit flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a clear and a new hit arrive on the same edge, the flag ends up 1.
- R12: With detect address FF001Fh enabled, only byte FF001Fh (lane 1 of fetch FF001Eh) is replaced. The neighbouring bytes FF001Ch..FF001Eh and FF0020h..FF0022h pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| fetch_valid | input | 1 | A fetch is in progress; qualifies hit-flag updates |
| fetch_addr | input | 24 | Fetch byte address |
| rom_data | input | 16 | Two ROM byte lanes |
| fetch_data | output | 16 | Lane data delivered to the CPU |

## Verification
On every cycle, the assertions check four things: a lane's output is either its ROM byte or 01h; disabled channels and addresses outside the window leave the data untouched; any lane that matches carries 01h; and the hit flags set, hold and clear as R10/R11 describe. Other behaviour depends on sequences of events, and only the bench scenarios can show it. These are the exact byte that is patched across a swept address range, the lane ordering for odd and even fetch addresses, the window edges, a write that takes effect live while a channel is enabled, and the priority of a set over a clear on the same edge.

// File: rtl/patch_pkg.sv
package patch_pkg;
  localparam logic [7:0] TRAP_OPCODE = 8'h01;
  localparam int CH_STRIDE = 4;
endpackage

// File: rtl/patch_rst_sync.sv
module patch_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/patch_regs.sv
module patch_regs
  import patch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_CH = 2,
  parameter int RA_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_ni,
  input  logic                           reg_wr,
  input  logic [RA_W-1:0]                reg_addr,
  input  logic [7:0]                     reg_wdata,
  output logic [7:0]                     reg_rdata,
  input  logic [NUM_CH-1:0]              hit_set,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  det_addr,
  output logic [NUM_CH-1:0]              det_en,
  output logic [NUM_CH-1:0]              hit_flag
);
  localparam int BYTES    = ADDR_W / 8;
  localparam int CTRL_OFF = CH_STRIDE * NUM_CH;
  localparam int HIT_OFF  = CTRL_OFF + 1;

  logic [NUM_CH-1:0][BYTES-1:0][7:0] abyte_q, abyte_d;
  logic [NUM_CH-1:0] en_q, en_d, hit_q, hit_d;
  logic ctrl_we, hit_we;

  assign ctrl_we = reg_wr && (reg_addr == RA_W'(CTRL_OFF));
  assign hit_we  = reg_wr && (reg_addr == RA_W'(HIT_OFF));

  // next state
  always_comb begin
    abyte_d = abyte_q;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (reg_wr && (reg_addr == RA_W'(c * CH_STRIDE + b)))
          abyte_d[c][b] = reg_wdata;
      end
    end
  end

  always_comb begin
    en_d  = ctrl_we ? reg_wdata[NUM_CH-1:0] : en_q;
    hit_d = (hit_we ? (hit_q & ~reg_wdata[NUM_CH-1:0]) : hit_q) | hit_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      abyte_q <= '0;
      en_q    <= '0;
      hit_q   <= '0;
    end else begin
      if (reg_wr)                abyte_q <= abyte_d;
      if (ctrl_we)               en_q    <= en_d;
      if (hit_we || (|hit_set))  hit_q   <= hit_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (reg_addr == RA_W'(c * CH_STRIDE + b)) reg_rdata = abyte_q[c][b];
      end
    end
    if (reg_addr == RA_W'(CTRL_OFF)) reg_rdata[NUM_CH-1:0] = en_q;
    if (reg_addr == RA_W'(HIT_OFF))  reg_rdata[NUM_CH-1:0] = hit_q;
  end

  assign det_addr = abyte_q;
  assign det_en   = en_q;
  assign hit_flag = hit_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit_chk
      AST_HIT_SET: assert property (@(posedge clk) disable iff (!rst_ni)
        hit_set[c] |=> hit_q[c]);  // R10
      AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
        (hit_q[c] && !(hit_we && reg_wdata[c])) |=> hit_q[c]);  // R10
      AST_HIT_W1C: assert property (@(posedge clk) disable iff (!rst_ni)
        (hit_we && reg_wdata[c] && !hit_set[c]) |=> !hit_q[c]);  // R11
    end
  endgenerate

  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctrl_we |=> $stable(en_q));  // R2
endmodule

// File: rtl/patch_lane.sv
module patch_lane
  import patch_pkg::*;
#(
  parameter int                ADDR_W = 24,
  parameter int                NUM_CH = 2,
  parameter logic [ADDR_W-1:0] ROM_LO = 24'hFF0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 24'hFFFFFF
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             lane_addr,
  input  logic [7:0]                    rom_byte,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] det_addr,
  input  logic [NUM_CH-1:0]             det_en,
  output logic [7:0]                    out_byte,
  output logic [NUM_CH-1:0]             ch_hit
);
  logic in_win;

  assign in_win = (lane_addr >= ROM_LO) && (lane_addr <= ROM_HI);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      assign ch_hit[c] = in_win && det_en[c] && (lane_addr == det_addr[c]);
    end
  endgenerate

  assign out_byte = (|ch_hit) ? TRAP_OPCODE : rom_byte;

  AST_SUB_VALUE: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_byte != rom_byte) |-> (out_byte == TRAP_OPCODE));  // R3
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    (det_en == '0) |-> (out_byte == rom_byte));  // R4
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    ((lane_addr < ROM_LO) || (lane_addr > ROM_HI)) |-> (out_byte == rom_byte));  // R5
  AST_MATCH_TRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (|ch_hit) |-> (out_byte == TRAP_OPCODE));  // R8
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
  import patch_pkg::*;
#(
  parameter int                ADDR_W = 24,
  parameter int                NUM_CH = 2,
  parameter int                LANES  = 2,
  parameter logic [ADDR_W-1:0] ROM_LO = 24'hFF0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 24'hFFFFFF,
  localparam int               DATA_W = 8 * LANES,
  localparam int               RA_W   = $clog2(CH_STRIDE * NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] fetch_data
);
  localparam logic [ADDR_W-1:0] LANE_MASK = ~ADDR_W'(LANES - 1);

  logic                          rst_s_n;
  logic [NUM_CH-1:0][ADDR_W-1:0] det_addr;
  logic [NUM_CH-1:0]             det_en;
  logic [NUM_CH-1:0]             hit_flag;
  logic [NUM_CH-1:0]             hit_any;
  logic [NUM_CH-1:0]             hit_set;
  logic [LANES-1:0][NUM_CH-1:0]  lane_hit;
  logic [ADDR_W-1:0]             base_addr;

  patch_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  patch_regs #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .RA_W   (RA_W)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_s_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hit_set   (hit_set),
    .det_addr  (det_addr),
    .det_en    (det_en),
    .hit_flag  (hit_flag)
  );

  assign base_addr = fetch_addr & LANE_MASK;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      patch_lane #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .ROM_LO (ROM_LO),
        .ROM_HI (ROM_HI)
      ) u_lane (
        .clk       (clk),
        .rst_ni    (rst_s_n),
        .lane_addr (base_addr + ADDR_W'(l)),
        .rom_byte  (rom_data[8*l +: 8]),
        .det_addr  (det_addr),
        .det_en    (det_en),
        .out_byte  (fetch_data[8*l +: 8]),
        .ch_hit    (lane_hit[l])
      );
    end
  endgenerate

  always_comb begin
    hit_any = '0;
    for (int l = 0; l < LANES; l++) hit_any = hit_any | lane_hit[l];
  end

  assign hit_set = fetch_valid ? hit_any : '0;

  AST_IDLE_NO_NEW_HIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!fetch_valid && !reg_wr) |=> $stable(hit_flag));  // R10
endmodule

// File: tb/fetch_patch_unit_tb.sv
module fetch_patch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        fetch_valid;
  logic [23:0] fetch_addr;
  logic [15:0] rom_data;
  logic [15:0] fetch_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0]  m_en;
  logic [23:0] m_d0, m_d1;

  always #5 clk = ~clk;

  fetch_patch_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .rom_data    (rom_data),
    .fetch_data  (fetch_data)
  );

  function automatic logic [7:0] rom_byte(input logic [23:0] a);
    return 8'h80 | {1'b0, a[6:0]};
  endfunction

  function automatic logic [7:0] model(input logic [23:0] a);
    logic win;
    win = (a >= 24'hFF0000) && (a <= 24'hFFFFFF);
    if (win && ((m_en[0] && a == m_d0) || (m_en[1] && a == m_d1))) return 8'h01;
    return rom_byte(a);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_det(input int ch, input logic [23:0] v);
    wr(4'(ch * 4 + 0), v[7:0]);
    wr(4'(ch * 4 + 1), v[15:8]);
    wr(4'(ch * 4 + 2), v[23:16]);
    if (ch == 0) m_d0 = v; else m_d1 = v;
  endtask

  task automatic set_en(input logic [1:0] e);
    wr(4'd8, {6'd0, e});
    m_en = e;
  endtask

  // drive a fetch, sample after settling, no clock edge in between (R7)
  task automatic fetch_chk(input string tag, input logic [23:0] a, input logic v);
    logic [23:0] b;
    @(negedge clk);
    fetch_valid = v;
    fetch_addr  = a;
    b = {a[23:1], 1'b0};
    rom_data = {rom_byte(b + 24'd1), rom_byte(b)};
    #1 chk(tag, fetch_data, {model(b + 24'd1), model(b)});
  endtask

  task automatic idle();
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    fetch_valid = 1'b0; fetch_addr = '0; rom_data = '0;
    m_en = '0; m_d0 = '0; m_d1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values across every offset (R2 unmapped offsets read zero)
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reset offset %0d", a), {8'h00, d}, 16'h0000);
    end

    // R2 readback of map
    set_det(0, 24'hFF001F);
    set_det(1, 24'hFF0024);
    wr(4'd3, 8'hAA); wr(4'd7, 8'h55); wr(4'd12, 8'h33);
    set_en(2'b00);
    rd(4'd0, d); chk("R2 ch0 low",  {8'h00, d}, 16'h001F);
    rd(4'd1, d); chk("R2 ch0 mid",  {8'h00, d}, 16'h0000);
    rd(4'd2, d); chk("R2 ch0 bank", {8'h00, d}, 16'h00FF);
    rd(4'd4, d); chk("R2 ch1 low",  {8'h00, d}, 16'h0024);
    rd(4'd6, d); chk("R2 ch1 bank", {8'h00, d}, 16'h00FF);
    rd(4'd3, d); chk("R2 unmapped 3", {8'h00, d}, 16'h0000);
    rd(4'd7, d); chk("R2 unmapped 7", {8'h00, d}, 16'h0000);
    rd(4'd12, d); chk("R2 unmapped 12", {8'h00, d}, 16'h0000);
    wr(4'd8, 8'hFF); rd(4'd8, d); chk("R2 enable field", {8'h00, d}, 16'h0003);
    set_en(2'b00);

    // R3 R4 R12 sweep over all enable combinations
    for (int e = 0; e < 4; e++) begin
      set_en(2'(e));
      for (int i = 0; i < 32; i++) begin
        fetch_chk($sformatf("R3/R4 sweep en=%0d i=%0d", e, i), 24'hFF0000 + 24'(2 * i), 1'b0);
      end
    end

    // R12 exact byte FF001F
    set_en(2'b01);
    fetch_chk("R12 FF001E pair", 24'hFF001E, 1'b0);
    chk("R12 lane1 trap", fetch_data, {8'h01, rom_byte(24'hFF001E)});
    fetch_chk("R12 FF001C pair", 24'hFF001C, 1'b0);
    chk("R12 FF001C untouched", fetch_data, {rom_byte(24'hFF001D), rom_byte(24'hFF001C)});
    fetch_chk("R12 FF0020 pair", 24'hFF0020, 1'b0);
    chk("R12 FF0020 untouched", fetch_data, {rom_byte(24'hFF0021), rom_byte(24'hFF0020)});

    // R6 odd fetch address aliases to the pair below
    fetch_chk("R6 odd FF001F", 24'hFF001F, 1'b0);
    chk("R6 odd lane order", fetch_data, {8'h01, rom_byte(24'hFF001E)});

    // R8 both channels on the same byte
    set_det(1, 24'hFF001F);
    set_en(2'b11);
    fetch_chk("R8 double match", 24'hFF001E, 1'b0);

    // R5 window edges
    set_det(0, 24'h7F001F);
    set_det(1, 24'hFEFFFF);
    fetch_chk("R5 outside low bank", 24'h7F001E, 1'b0);
    fetch_chk("R5 just below window", 24'hFEFFFE, 1'b0);
    chk("R5 below window untouched", fetch_data, {rom_byte(24'hFEFFFF), rom_byte(24'hFEFFFE)});
    set_det(1, 24'hFF0000);
    fetch_chk("R5 window low edge", 24'hFF0000, 1'b0);
    set_det(0, 24'hFFFFFF);
    fetch_chk("R5 window high edge", 24'hFFFFFE, 1'b0);

    // R9 live update while enabled
    set_det(0, 24'hFF001F);
    set_en(2'b01);
    wr(4'd0, 8'h20); m_d0 = 24'hFF0020;
    fetch_chk("R9 new address live", 24'hFF0020, 1'b0);
    fetch_chk("R9 old address gone", 24'hFF001E, 1'b0);

    // R10 hit flags
    wr(4'd9, 8'h03);
    fetch_chk("R10 patched valid fetch", 24'hFF0020, 1'b1);
    idle();
    rd(4'd9, d); chk("R10 ch0 flag set only", {8'h00, d}, 16'h0001);
    fetch_chk("R10 unpatched valid fetch", 24'hFF0030, 1'b1);
    idle();
    rd(4'd9, d); chk("R10 flag sticky", {8'h00, d}, 16'h0001);

    // R11 write-one-to-clear
    wr(4'd9, 8'h00); rd(4'd9, d); chk("R11 zero write no effect", {8'h00, d}, 16'h0001);
    wr(4'd9, 8'h01); rd(4'd9, d); chk("R11 one clears", {8'h00, d}, 16'h0000);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 24'hFF0020;
    rom_data = {rom_byte(24'hFF0021), rom_byte(24'hFF0020)};
    reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; fetch_valid = 1'b0;
    rd(4'd9, d); chk("R11 set wins over clear", {8'h00, d}, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule